// File: doc/BRIEF.md
# Multi-Mode Interval Timer with Polarity Select

This block is a general-purpose up-counting timer with eight behaviours, picked by a 3-bit mode field. It can run freely, run once, count external edges, make a PWM waveform, time-stamp input edges, toggle on a compare match, count only while a gate input is at its active level, or wait for a starting edge and then time-stamp later edges. A single polarity bit is read in a different way by each mode. It selects the output level while the timer is stopped, which input edge counts or captures, which gate level lets the counter run, and the sense of the PWM waveform.

Software-side registers are shown as simple load strobes sharing one data bus. A configuration write sets the run bit, the polarity and the mode together. The external input passes through a synchronizer before any edge or level is taken from it. The block drives a registered timer output and a one-cycle interrupt pulse. The counter and the capture register can be read directly on output ports.

Top module: `mm_timer`

## Requirements
- R1: After reset, `count`=0, `capture`=0, `tmrOut`=0, `irq`=0 and `enabled`=0. A `cfgWr` pulse loads `cfgEnable`, `cfgPol` and `cfgMode`. The mode codes are 0 one-shot, 1 continuous, 2 counter, 3 PWM, 4 capture, 5 compare, 6 gated and 7 capture/compare.
- R2: While the timer is stopped, `count` holds its value and `irq` stays 0. One cycle after the polarity register changes, `tmrOut` equals it.
- R3: In continuous mode the count rises by one each cycle. On the edge where the count equals the reload value, the count returns to 1, `irq` is high for that one cycle and `tmrOut` toggles.
- R4: In one-shot mode the reload behaves as in R3 and also clears `enabled`. The count then stays at 1, and `tmrOut` returns to the polarity level one cycle later.
- R5: In counter mode the count advances once per input edge: rising edges when polarity is 0, falling edges when it is 1. An input change takes effect on the third clock edge after it.
- R6: In PWM mode with polarity 0, `tmrOut` goes to 1 on the edge where the count equals the compare value, and goes to 0 on reload. With polarity 1 both levels are inverted, and the stopped level is 1.
- R7: In capture mode, a rising input edge (polarity 0) copies the count that was current just before the edge into `capture` and pulses `irq`. A falling edge then does neither.
- R8: In compare mode, a count equal to the compare value toggles `tmrOut` and pulses `irq`. The count keeps rising and the reload value is ignored.
- R9: In gated mode with polarity 0, the count advances only while the synchronized input is high. `irq` pulses on its falling edge, not on its rising edge.
- R10: In capture/compare mode the count waits at its value until the first selected input edge. Counting starts on the next cycle. Each later selected edge copies the count into `capture` and pulses `irq`. The arming edge does not pulse `irq`.
- R11: Changing the polarity bit while the timer runs leaves `tmrOut` unchanged until a timer event occurs or the timer is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | Load the run bit, polarity and mode |
| cfgEnable | input | 1 | Run bit value to load |
| cfgPol | input | 1 | Polarity value to load |
| cfgMode | input | 3 | Mode code to load |
| ldReload | input | 1 | Load the reload register from `wrData` |
| ldCompare | input | 1 | Load the PWM/compare register from `wrData` |
| ldCount | input | 1 | Load the counter from `wrData` |
| wrData | input | WIDTH | Shared load data |
| tmrIn | input | 1 | Asynchronous external timer input |
| tmrOut | output | 1 | Registered timer output |
| irq | output | 1 | One-cycle interrupt pulse |
| count | output | WIDTH | Current counter value |
| capture | output | WIDTH | Last captured count |
| enabled | output | 1 | Run bit as currently held |

## Verification
If the stored run bit or polarity is wrong, `tmrOut` moves away from the expected level within one cycle of a stop, or toggles one cycle early or late around a reload. A wrong synchronizer depth or a wrong edge-select decode shifts the first counter advance or capture away from the third edge after an input change, so it shows on `count` and `capture` at once. A bad arming flag in capture/compare mode shows as the count leaving its parked value too early, or an `irq` on the arming edge.

// File: rtl/mm_timer_pkg.sv
package mm_timer_pkg;

  typedef enum logic [2:0] {
    MODE_ONESHOT = 3'd0,
    MODE_CONT    = 3'd1,
    MODE_COUNT   = 3'd2,
    MODE_PWM     = 3'd3,
    MODE_CAPT    = 3'd4,
    MODE_CMP     = 3'd5,
    MODE_GATED   = 3'd6,
    MODE_CAPCMP  = 3'd7
  } tmode_e;

  // Strobes and static qualifiers handed from control to datapath.
  typedef struct packed {
    logic en;
    logic pol;
    logic advance;
    logic captureNow;
    logic edgeIrq;
    logic reloadOk;
    logic pwmMode;
    logic cmpMode;
    logic oneShot;
  } strobe_t;

endpackage

// File: rtl/mm_timer_sync.sv
module mm_timer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '0;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/mm_timer_ctrl.sv
module mm_timer_ctrl
  import mm_timer_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cfgWr,
  input  logic     cfgEnable,
  input  logic     cfgPol,
  input  logic [2:0] cfgMode,
  input  logic     inSync,
  input  logic     reloadEvt,
  output strobe_t  st
);

  logic   enQ;
  logic   polQ;
  logic   armedQ;
  logic   prevQ;
  tmode_e modeQ;

  logic rise;
  logic fall;
  logic actEdge;
  logic gateEnd;
  logic levelOn;

  assign rise    = inSync & ~prevQ;
  assign fall    = ~inSync & prevQ;
  assign actEdge = polQ ? fall : rise;
  assign gateEnd = polQ ? rise : fall;
  assign levelOn = inSync ^ polQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ    <= 1'b0;
      polQ   <= 1'b0;
      armedQ <= 1'b0;
      prevQ  <= 1'b0;
      modeQ  <= MODE_ONESHOT;
    end else begin
      prevQ <= inSync;
      if (cfgWr) begin
        enQ   <= cfgEnable;
        polQ  <= cfgPol;
        modeQ <= tmode_e'(cfgMode);
      end else if (reloadEvt && modeQ == MODE_ONESHOT) begin
        enQ <= 1'b0;
      end
      if (!enQ || cfgWr) armedQ <= 1'b0;
      else if (modeQ == MODE_CAPCMP && actEdge) armedQ <= 1'b1;
    end
  end

  always_comb begin
    st            = '0;
    st.en         = enQ;
    st.pol        = polQ;
    st.reloadOk   = (modeQ != MODE_CMP);
    st.pwmMode    = (modeQ == MODE_PWM);
    st.cmpMode    = (modeQ == MODE_CMP);
    st.oneShot    = (modeQ == MODE_ONESHOT);
    case (modeQ)
      MODE_ONESHOT, MODE_CONT, MODE_PWM, MODE_CMP: begin
        st.advance = enQ;
      end
      MODE_COUNT: begin
        st.advance = enQ & actEdge;
      end
      MODE_CAPT: begin
        st.advance    = enQ;
        st.captureNow = enQ & actEdge;
      end
      MODE_GATED: begin
        st.advance = enQ & levelOn;
        st.edgeIrq = enQ & gateEnd;
      end
      MODE_CAPCMP: begin
        st.advance    = enQ & armedQ;
        st.captureNow = enQ & armedQ & actEdge;
      end
      default: st.advance = 1'b0;
    endcase
    if (st.captureNow) st.edgeIrq = 1'b1;
  end

endmodule

// File: rtl/mm_timer_dp.sv
module mm_timer_dp
  import mm_timer_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          st,
  input  logic             ldReload,
  input  logic             ldCompare,
  input  logic             ldCount,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] capture,
  output logic             tmrOut,
  output logic             irq,
  output logic             reloadEvt,
  output logic             cmpMatch
);

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] reloadQ;
  logic [WIDTH-1:0] compareQ;

  assign reloadEvt = st.advance & st.reloadOk & (count == reloadQ);
  assign cmpMatch  = st.advance & (st.pwmMode | st.cmpMode) & (count == compareQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadQ  <= '1;
      compareQ <= '0;
      count    <= '0;
      capture  <= '0;
      tmrOut   <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (ldReload)  reloadQ  <= wrData;
      if (ldCompare) compareQ <= wrData;

      if (ldCount)         count <= wrData;
      else if (reloadEvt)  count <= ONE;
      else if (st.advance) count <= count + ONE;

      if (st.captureNow) capture <= count;

      if (!st.en)         tmrOut <= st.pol;
      else if (reloadEvt) tmrOut <= st.pwmMode ? st.pol : ~tmrOut;
      else if (cmpMatch)  tmrOut <= st.pwmMode ? ~st.pol : ~tmrOut;

      irq <= reloadEvt | (cmpMatch & st.cmpMode) | st.edgeIrq;
    end
  end

endmodule

// File: rtl/mm_timer.sv
module mm_timer
  import mm_timer_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic             cfgEnable,
  input  logic             cfgPol,
  input  logic [2:0]       cfgMode,
  input  logic             ldReload,
  input  logic             ldCompare,
  input  logic             ldCount,
  input  logic [WIDTH-1:0] wrData,
  input  logic             tmrIn,
  output logic             tmrOut,
  output logic             irq,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] capture,
  output logic             enabled
);

  logic    inSync;
  logic    reloadEvt;
  logic    cmpMatch;
  strobe_t st;

  mm_timer_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rstN (rstN),
    .din  (tmrIn),
    .dout (inSync)
  );

  mm_timer_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWr     (cfgWr),
    .cfgEnable (cfgEnable),
    .cfgPol    (cfgPol),
    .cfgMode   (cfgMode),
    .inSync    (inSync),
    .reloadEvt (reloadEvt),
    .st        (st)
  );

  mm_timer_dp #(.WIDTH(WIDTH)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .ldReload  (ldReload),
    .ldCompare (ldCompare),
    .ldCount   (ldCount),
    .wrData    (wrData),
    .count     (count),
    .capture   (capture),
    .tmrOut    (tmrOut),
    .irq       (irq),
    .reloadEvt (reloadEvt),
    .cmpMatch  (cmpMatch)
  );

  assign enabled = st.en;

endmodule

// File: rtl/mm_timer_chk.sv
module mm_timer_chk
  import mm_timer_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input strobe_t          st,
  input logic             reloadEvt,
  input logic             cmpMatch,
  input logic             ldCount,
  input logic             cfgWr,
  input logic [WIDTH-1:0] count,
  input logic             irq,
  input logic             tmrOut,
  input logic             enabled
);

  a_r2_hold_off: assert property (@(posedge clk) disable iff (!rstN)
    (!enabled && !ldCount) |=> $stable(count));

  a_r2_idle_level: assert property (@(posedge clk) disable iff (!rstN)
    !st.en |=> (tmrOut == $past(st.pol)));

  a_r3_reload_to_one: assert property (@(posedge clk) disable iff (!rstN)
    (reloadEvt && !ldCount) |=> (count == {{(WIDTH-1){1'b0}}, 1'b1}));

  a_r3_reload_irq: assert property (@(posedge clk) disable iff (!rstN)
    reloadEvt |=> irq);

  a_r4_oneshot_stops: assert property (@(posedge clk) disable iff (!rstN)
    (reloadEvt && st.oneShot && !cfgWr) |=> !enabled);

  a_r11_out_steady: assert property (@(posedge clk) disable iff (!rstN)
    (st.en && !reloadEvt && !cmpMatch) |=> $stable(tmrOut));

endmodule

bind mm_timer mm_timer_chk #(.WIDTH(WIDTH)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .st        (st),
  .reloadEvt (reloadEvt),
  .cmpMatch  (cmpMatch),
  .ldCount   (ldCount),
  .cfgWr     (cfgWr),
  .count     (count),
  .irq       (irq),
  .tmrOut    (tmrOut),
  .enabled   (enabled)
);

// File: tb/mm_timer_tb_top.sv
module mm_timer_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWr, cfgEnable, cfgPol;
  logic [2:0]  cfgMode;
  logic        ldReload, ldCompare, ldCount;
  logic [15:0] wrData;
  logic        tmrIn;
  logic        tmrOut, irq, enabled;
  logic [15:0] count, capture;

  int nChk  = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  mm_timer dut_i (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgEnable(cfgEnable),
    .cfgPol(cfgPol), .cfgMode(cfgMode), .ldReload(ldReload),
    .ldCompare(ldCompare), .ldCount(ldCount), .wrData(wrData),
    .tmrIn(tmrIn), .tmrOut(tmrOut), .irq(irq), .count(count),
    .capture(capture), .enabled(enabled)
  );

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setCfg(input logic en, input logic pol, input logic [2:0] mode);
    cfgWr = 1'b1; cfgEnable = en; cfgPol = pol; cfgMode = mode;
    step();
    cfgWr = 1'b0;
  endtask

  task automatic loadRegs(input logic [15:0] rl, input logic [15:0] cp, input logic [15:0] cn);
    ldReload = 1'b1; wrData = rl; step(); ldReload = 1'b0;
    ldCompare = 1'b1; wrData = cp; step(); ldCompare = 1'b0;
    ldCount = 1'b1; wrData = cn; step(); ldCount = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 count after reset", count, 0);
    chk("R1 capture after reset", capture, 0);
    chk("R1 tmrOut after reset", tmrOut, 0);
    chk("R1 irq after reset", irq, 0);
    chk("R1 enabled after reset", enabled, 0);
  endtask

  task automatic testStopped();
    setCfg(1'b0, 1'b1, 3'd0);
    chk("R2 out lags pol by one cycle", tmrOut, 0);
    step();
    chk("R2 out follows pol when stopped", tmrOut, 1);
    tmrIn = 1'b1; step(5); tmrIn = 1'b0; step(5);
    chk("R2 count held when stopped", count, 0);
    chk("R2 no irq when stopped", irq, 0);
  endtask

  task automatic testContinuous();
    setCfg(1'b0, 1'b0, 3'd1);
    loadRegs(16'd5, 16'd0, 16'd1);
    setCfg(1'b1, 1'b0, 3'd1);
    chk("R1 enabled after cfg write", enabled, 1);
    for (int k = 1; k <= 4; k++) begin
      step();
      chk("R3 count increments", count, 1 + k);
    end
    step();
    chk("R3 count back to 1 at reload", count, 1);
    chk("R3 irq at reload", irq, 1);
    chk("R3 out toggled at reload", tmrOut, 1);
    step();
    chk("R3 irq one cycle", irq, 0);
    chk("R3 continues counting", count, 2);
    step(4);
    chk("R3 second reload irq", irq, 1);
    chk("R3 second toggle", tmrOut, 0);
  endtask

  task automatic testOneShot();
    setCfg(1'b0, 1'b1, 3'd0);
    loadRegs(16'd3, 16'd0, 16'd1);
    setCfg(1'b1, 1'b1, 3'd0);
    chk("R4 idle level before run", tmrOut, 1);
    step(3);
    chk("R4 reload count", count, 1);
    chk("R4 reload irq", irq, 1);
    chk("R4 reload toggles out", tmrOut, 0);
    chk("R4 enable cleared", enabled, 0);
    step();
    chk("R4 out back to pol", tmrOut, 1);
    step();
    chk("R4 count stays after stop", count, 1);
    chk("R4 no further irq", irq, 0);
  endtask

  task automatic testCounter();
    setCfg(1'b0, 1'b0, 3'd2);
    tmrIn = 1'b0;
    loadRegs(16'd100, 16'd0, 16'd1);
    setCfg(1'b1, 1'b0, 3'd2);
    tmrIn = 1'b1;
    step(2);
    chk("R5 no advance before third edge", count, 1);
    step();
    chk("R5 rising edge advances", count, 2);
    tmrIn = 1'b0;
    step(4);
    chk("R5 falling edge ignored pol0", count, 2);
    setCfg(1'b1, 1'b1, 3'd2);
    tmrIn = 1'b1;
    step(4);
    chk("R5 rising edge ignored pol1", count, 2);
    tmrIn = 1'b0;
    step(2);
    chk("R5 falling not yet pol1", count, 2);
    step();
    chk("R5 falling edge advances pol1", count, 3);
  endtask

  task automatic testPwm();
    setCfg(1'b0, 1'b0, 3'd3);
    loadRegs(16'd6, 16'd3, 16'd1);
    chk("R6 stopped low pol0", tmrOut, 0);
    setCfg(1'b1, 1'b0, 3'd3);
    step(2);
    chk("R6 low before match", tmrOut, 0);
    step();
    chk("R6 high at match", tmrOut, 1);
    step(2);
    chk("R6 stays high", tmrOut, 1);
    step();
    chk("R6 low at reload", tmrOut, 0);
    chk("R6 reload irq", irq, 1);
    setCfg(1'b0, 1'b1, 3'd3);
    step();
    chk("R6 stopped high pol1", tmrOut, 1);
    loadRegs(16'd6, 16'd3, 16'd1);
    setCfg(1'b1, 1'b1, 3'd3);
    step(3);
    chk("R6 low at match pol1", tmrOut, 0);
    step(3);
    chk("R6 high at reload pol1", tmrOut, 1);
  endtask

  task automatic testCapture();
    setCfg(1'b0, 1'b0, 3'd4);
    tmrIn = 1'b0;
    loadRegs(16'd1000, 16'd0, 16'd1);
    setCfg(1'b1, 1'b0, 3'd4);
    tmrIn = 1'b1;
    step(3);
    chk("R7 capture on rising edge", capture, 3);
    chk("R7 capture irq", irq, 1);
    step();
    chk("R7 irq one cycle", irq, 0);
    tmrIn = 1'b0;
    step(3);
    chk("R7 falling edge no irq", irq, 0);
    chk("R7 falling edge no capture", capture, 3);
  endtask

  task automatic testCompare();
    setCfg(1'b0, 1'b0, 3'd5);
    loadRegs(16'd2, 16'd4, 16'd1);
    setCfg(1'b1, 1'b0, 3'd5);
    step(2);
    chk("R8 reload value ignored", count, 3);
    chk("R8 no irq at reload value", irq, 0);
    step(2);
    chk("R8 count passes compare", count, 5);
    chk("R8 out toggles at match", tmrOut, 1);
    chk("R8 irq at match", irq, 1);
    step();
    chk("R8 keeps counting", count, 6);
    chk("R8 irq one cycle", irq, 0);
  endtask

  task automatic testGated();
    setCfg(1'b0, 1'b0, 3'd6);
    tmrIn = 1'b0;
    loadRegs(16'd1000, 16'd0, 16'd1);
    setCfg(1'b1, 1'b0, 3'd6);
    step(3);
    chk("R9 no count while gate low", count, 1);
    tmrIn = 1'b1;
    step(2);
    chk("R9 gate not yet seen", count, 1);
    step();
    chk("R9 counts when gate high", count, 2);
    chk("R9 no irq on rising edge", irq, 0);
    step(2);
    chk("R9 keeps counting", count, 4);
    tmrIn = 1'b0;
    step(3);
    chk("R9 stops after gate low", count, 6);
    chk("R9 irq on falling edge", irq, 1);
    step();
    chk("R9 held while gate low", count, 6);
    chk("R9 irq one cycle", irq, 0);
  endtask

  task automatic testCapCmp();
    setCfg(1'b0, 1'b0, 3'd7);
    tmrIn = 1'b0;
    loadRegs(16'd1000, 16'd0, 16'd1);
    setCfg(1'b1, 1'b0, 3'd7);
    step(4);
    chk("R10 parked before arming", count, 1);
    tmrIn = 1'b1;
    step(3);
    chk("R10 arming edge no count", count, 1);
    chk("R10 arming edge no irq", irq, 0);
    step();
    chk("R10 counts after arming", count, 2);
    step();
    tmrIn = 1'b0;
    step(4);
    chk("R10 running", count, 7);
    tmrIn = 1'b1;
    step(3);
    chk("R10 later edge captures", capture, 9);
    chk("R10 later edge irq", irq, 1);
    chk("R10 count continues", count, 10);
  endtask

  task automatic testPolWhileRunning();
    setCfg(1'b0, 1'b0, 3'd1);
    loadRegs(16'd1000, 16'd0, 16'd1);
    step();
    chk("R11 idle low", tmrOut, 0);
    setCfg(1'b1, 1'b0, 3'd1);
    setCfg(1'b1, 1'b1, 3'd1);
    step(3);
    chk("R11 pol change no effect while running", tmrOut, 0);
    setCfg(1'b0, 1'b1, 3'd1);
    step();
    chk("R11 pol applies after stop", tmrOut, 1);
  endtask

  initial begin
    rstN = 1'b0; cfgWr = 1'b0; cfgEnable = 1'b0; cfgPol = 1'b0; cfgMode = 3'd0;
    ldReload = 1'b0; ldCompare = 1'b0; ldCount = 1'b0; wrData = '0; tmrIn = 1'b0;
    step(3);
    rstN = 1'b1;
    step();
    testReset();
    testStopped();
    testContinuous();
    testOneShot();
    testCounter();
    testPwm();
    testCapture();
    testCompare();
    testGated();
    testCapCmp();
    testPolWhileRunning();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    #(4 * 100000);
    nChk++;
    nFail++;
    $display("FAIL watchdog all-R actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule